// File: doc/BRIEF.md
# Half-Bridge Fault Status Encoder

This block keeps the fault bookkeeping for a group of half-bridge output stages and turns it into one status word for the serial readout path. Each channel carries a 2-bit state that reports whether the bridge is off, running, stopped on an overcurrent, or flagged for an under-load. A small set of global flags sits next to the channel states: overcurrent, under-load, supply failure and thermal warning are in the word, and a latched thermal-shutdown flag is a separate output. The block also tells the driver controller which bridges must be held off.

Comparator results arrive as synchronous levels. An overcurrent must last a programmable number of cycles before it counts, and each channel has its own timer for this. All channels share a single under-load timer. It runs while any running channel sees a light load, so a channel that starts to see a light load later only waits for the time the timer has left. A status-reset strobe, raised once for each valid command frame that asks for it, clears the latched faults.

Top module: `hb_fault_status`

## Requirements
- R1: After reset the status word, the latch-off vector and the thermal-shutdown flag are all zero.
- R2: A channel state code is 00 (off), 11 (running), 10 (under-load) or 01 (overcurrent). An off channel whose enable is high moves to 11 on the next clock. Any channel whose enable is low is 00 on the next clock, whatever its state.
- R3: If a channel's overcurrent level stays high for OC_DLY consecutive clocks while the channel is in 11 or 10, the channel goes to 01. Status bit 15 is then set and the channel's latch-off bit is raised. A shorter pulse restarts the count.
- R4: A channel in 01 never moves to 10, whatever its under-load input does. An overcurrent that qualifies while the channel is in 10 moves it to 01.
- R5: One under-load timer is shared by all channels. It counts while at least one channel in 11 has its under-load level high, and it restarts when no channel does. On the UL_DLY-th such clock, every channel then in 11 with its level high moves to 10, and status bit 13 is set.
- R6: A channel that enters 10 raises its latch-off bit only if the under-load shutdown input is high on the clock where it enters. The bit stays up until the channel leaves 10.
- R7: A status-reset strobe moves every enabled channel in 10 or 01 to 11 and clears bits 15 and 13. If a new fault qualifies on the same clock, its flag stays set.
- R8: The thermal-shutdown flag and a channel's thermal latch-off are set when that channel's thermal-shutdown level is high. They clear only on a status-reset strobe given while the level is low.
- R9: Status bit 0 follows the thermal-warning level, and bit 14 follows the OR of the undervoltage and overvoltage levels, each one clock later and without latching.
- R10: Channel n (counting from 0) reports its state in status bits 2n+2 down to 2n+1. Bit 15 is overcurrent, bit 14 is supply failure, bit 13 is under-load and bit 0 is thermal warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also used as power-on reset |
| ch_en | input | NUM_CH | Per-channel bridge enable |
| oc_lvl | input | NUM_CH | Per-channel overcurrent comparator level |
| ul_lvl | input | NUM_CH | Per-channel under-load comparator level |
| tsd_lvl | input | NUM_CH | Per-channel thermal-shutdown level |
| tw_lvl | input | 1 | Thermal-warning level |
| uv_lvl | input | 1 | Supply undervoltage level |
| ov_lvl | input | 1 | Supply overvoltage level |
| uld_shdn | input | 1 | Under-load shutdown enable |
| srst | input | 1 | One-clock status-reset strobe from a valid frame |
| status_word | output | 2*NUM_CH+4 | Packed status word |
| latch_off | output | NUM_CH | Per-channel request to hold the bridge off |
| tsd_flag | output | 1 | Latched thermal-shutdown flag |

## Verification
The properties assume that every input is a clean synchronous level that changes only between clock edges, and that the status-reset strobe is a single-cycle pulse that the frame logic has already validated. The stimulus drives all inputs on the falling clock edge and raises the strobe for exactly one cycle. It drops the comparator levels before it issues a strobe, so that a fault does not re-qualify at once unless a test wants that. The sharing of the under-load timer is tested by having a second channel start to see its light load part-way through the first channel's wait. Overcurrent masking is tested by holding the under-load level high on a channel that has already stopped on an overcurrent.

// File: rtl/hb_fault_pkg.sv
package hb_fault_pkg;
   typedef enum logic [1:0] {
      HB_OFF = 2'b00,
      HB_OC  = 2'b01,
      HB_UL  = 2'b10,
      HB_ON  = 2'b11
   } hb_st_e;

   function automatic int sw_width(input int n_ch);
      return 2 * n_ch + 4;
   endfunction
endpackage

// File: rtl/hb_dly_timer.sv
module hb_dly_timer #(
   parameter int DLY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expire
);
   generate
      if (DLY <= 1) begin : g_direct
         assign expire = arm;
      end else begin : g_count
         localparam int CW = $clog2(DLY);
         localparam logic [CW-1:0] LAST = CW'(DLY - 1);
         logic [CW-1:0] cnt_q;
         assign expire = arm && (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (arm && !expire)  cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
         end
      end
   endgenerate
endmodule

// File: rtl/hb_chan_fsm.sv
module hb_chan_fsm
   import hb_fault_pkg::*;
#(
   parameter int OC_DLY = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   oc_lvl,
   input  logic   ul_lvl,
   input  logic   ul_expire,
   input  logic   uld_shdn,
   input  logic   srst,
   output hb_st_e st,
   output logic   oc_fire,
   output logic   ul_pend,
   output logic   ul_off
);
   hb_st_e st_q, st_d;
   logic   ul_off_q;
   logic   oc_arm;

   assign oc_arm  = en && oc_lvl && (st_q == HB_ON || st_q == HB_UL);
   assign ul_pend = en && ul_lvl && (st_q == HB_ON);

   hb_dly_timer #(.DLY(OC_DLY)) u_oc_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (oc_arm),
      .expire (oc_fire)
   );

   always_comb begin
      st_d = st_q;
      if (!en) begin
         st_d = HB_OFF;
      end else begin
         unique case (st_q)
            HB_OFF: st_d = HB_ON;
            HB_ON: begin
               if (oc_fire)                    st_d = HB_OC;
               else if (ul_expire && ul_pend)  st_d = HB_UL;
            end
            HB_UL: begin
               if (oc_fire)    st_d = HB_OC;
               else if (srst)  st_d = HB_ON;
            end
            HB_OC: if (srst) st_d = HB_ON;
            default: st_d = HB_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= HB_OFF;
         ul_off_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         ul_off_q <= (st_d == HB_UL) && ((st_q == HB_UL) ? ul_off_q : uld_shdn);
      end
   end

   assign st     = st_q;
   assign ul_off = ul_off_q;
endmodule

// File: rtl/hb_fault_status.sv
module hb_fault_status
   import hb_fault_pkg::*;
#(
   parameter int NUM_CH = 6,
   parameter int OC_DLY = 5000,
   parameter int UL_DLY = 70000,
   localparam int SW_W  = 2 * NUM_CH + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] oc_lvl,
   input  logic [NUM_CH-1:0] ul_lvl,
   input  logic [NUM_CH-1:0] tsd_lvl,
   input  logic              tw_lvl,
   input  logic              uv_lvl,
   input  logic              ov_lvl,
   input  logic              uld_shdn,
   input  logic              srst,
   output logic [SW_W-1:0]   status_word,
   output logic [NUM_CH-1:0] latch_off,
   output logic              tsd_flag
);
   generate
      if (NUM_CH < 1)                    begin : g_bad_ch  $error("NUM_CH must be at least 1"); end
      if (OC_DLY < 1)                    begin : g_bad_oc  $error("OC_DLY must be at least 1"); end
      if (UL_DLY < 1)                    begin : g_bad_ul  $error("UL_DLY must be at least 1"); end
      if (SW_W != sw_width(NUM_CH))      begin : g_bad_sw  $error("status width mismatch"); end
   endgenerate

   hb_st_e            st     [NUM_CH];
   logic [NUM_CH-1:0] oc_fire, ul_pend, ul_off;
   logic [NUM_CH-1:0] tsd_lat_q;
   logic              ul_expire;
   logic              oc_flag_q, ul_flag_q, tsd_flag_q, psf_q, tw_q;

   hb_dly_timer #(.DLY(UL_DLY)) u_ul_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (|ul_pend),
      .expire (ul_expire)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         hb_chan_fsm #(.OC_DLY(OC_DLY)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[i]),
            .oc_lvl    (oc_lvl[i]),
            .ul_lvl    (ul_lvl[i]),
            .ul_expire (ul_expire),
            .uld_shdn  (uld_shdn),
            .srst      (srst),
            .st        (st[i]),
            .oc_fire   (oc_fire[i]),
            .ul_pend   (ul_pend[i]),
            .ul_off    (ul_off[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_flag_q  <= 1'b0;
         ul_flag_q  <= 1'b0;
         tsd_flag_q <= 1'b0;
         tsd_lat_q  <= '0;
         psf_q      <= 1'b0;
         tw_q       <= 1'b0;
      end else begin
         oc_flag_q  <= (|oc_fire) || (oc_flag_q && !srst);
         ul_flag_q  <= (ul_expire && |ul_pend) || (ul_flag_q && !srst);
         tsd_flag_q <= (|tsd_lvl) || (tsd_flag_q && !srst);
         tsd_lat_q  <= tsd_lvl | (tsd_lat_q & {NUM_CH{!srst}});
         psf_q      <= uv_lvl || ov_lvl;
         tw_q       <= tw_lvl;
      end
   end

   always_comb begin
      status_word         = '0;
      status_word[SW_W-1] = oc_flag_q;
      status_word[SW_W-2] = psf_q;
      status_word[SW_W-3] = ul_flag_q;
      for (int i = 0; i < NUM_CH; i++) begin
         status_word[2*i+1 +: 2] = st[i];
         latch_off[i] = (st[i] == HB_OC) || ul_off[i] || tsd_lat_q[i];
      end
      status_word[0] = tw_q;
   end

   assign tsd_flag = tsd_flag_q;
endmodule

// File: rtl/hb_fault_status_chk.sv
module hb_fault_status_chk #(
   parameter int NUM_CH = 6,
   localparam int SW_W  = 2 * NUM_CH + 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] tsd_lvl,
   input logic              uv_lvl,
   input logic              ov_lvl,
   input logic              srst,
   input logic [SW_W-1:0]   status_word,
   input logic [NUM_CH-1:0] latch_off,
   input logic              tsd_flag
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         // R2: a dropped enable forces the off code
         p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |=> status_word[2*i+1 +: 2] == 2'b00);
         // R4: overcurrent never falls back to under-load
         p_no_oc_to_ul_r4: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[2*i+1 +: 2] == 2'b01 |=> status_word[2*i+1 +: 2] != 2'b10);
         // R3: overcurrent state implies global flag and latch-off
         p_oc_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[2*i+1 +: 2] == 2'b01 |-> (status_word[SW_W-1] && latch_off[i]));
         // R5: under-load state implies global under-load flag
         p_ul_flagged_r5: assert property (@(posedge clk) disable iff (!rst_n)
            status_word[2*i+1 +: 2] == 2'b10 |-> status_word[SW_W-3]);
         // R8: thermal level always produces latch-off next cycle
         p_tsd_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tsd_lvl[i] |=> latch_off[i] && tsd_flag);
      end
   endgenerate

   // R8: thermal flag holds without a strobe
   p_tsd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_flag && !srst |=> tsd_flag);
   // R9: supply failure bit tracks the levels
   p_psf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_lvl || ov_lvl) |=> status_word[SW_W-2]);
   p_psf_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(uv_lvl || ov_lvl) |=> !status_word[SW_W-2]);
endmodule

bind hb_fault_status hb_fault_status_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ch_en       (ch_en),
   .tsd_lvl     (tsd_lvl),
   .uv_lvl      (uv_lvl),
   .ov_lvl      (ov_lvl),
   .srst        (srst),
   .status_word (status_word),
   .latch_off   (latch_off),
   .tsd_flag    (tsd_flag)
);

// File: tb/hb_fault_status_tb_top.sv
module hb_fault_status_tb_top;
   localparam int N   = 6;
   localparam int OCD = 4;
   localparam int ULD = 10;
   localparam int W   = 2 * N + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] ch_en = '0, oc_lvl = '0, ul_lvl = '0, tsd_lvl = '0;
   logic tw_lvl = 1'b0, uv_lvl = 1'b0, ov_lvl = 1'b0, uld_shdn = 1'b0, srst = 1'b0;
   logic [W-1:0] status_word;
   logic [N-1:0] latch_off;
   logic tsd_flag;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hb_fault_status #(.NUM_CH(N), .OC_DLY(OCD), .UL_DLY(ULD)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .oc_lvl(oc_lvl), .ul_lvl(ul_lvl),
      .tsd_lvl(tsd_lvl), .tw_lvl(tw_lvl), .uv_lvl(uv_lvl), .ov_lvl(ov_lvl),
      .uld_shdn(uld_shdn), .srst(srst), .status_word(status_word),
      .latch_off(latch_off), .tsd_flag(tsd_flag)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] fld(input int c);
      return status_word[2*c+1 +: 2];
   endfunction

   task automatic pulse_srst();
      srst = 1'b1; tick(1); srst = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      check("R1 status", 32'(status_word), 0);
      check("R1 latch", 32'(latch_off), 0);
      check("R1 tsd", 32'(tsd_flag), 0);

      // R2 / R10: sweep every enable pattern
      for (int m = 0; m < (1 << N); m++) begin
         logic [W-1:0] exp;
         ch_en = N'(m);
         tick(1);
         exp = '0;
         for (int i = 0; i < N; i++) if (m[i]) exp[2*i+1 +: 2] = 2'b11;
         check("R2/R10 enable sweep", 32'(status_word), 32'(exp));
         ch_en = '0;
         tick(1);
         check("R2 disable", 32'(status_word), 0);
      end

      // R3 and R7 per channel
      ch_en = '1;
      tick(1);
      for (int c = 0; c < N; c++) begin
         oc_lvl[c] = 1'b1;
         tick(OCD - 1);
         check("R3 before delay", 32'(fld(c)), 32'h3);
         check("R3 no flag yet", 32'(status_word[15]), 0);
         tick(1);
         check("R3 latched state", 32'(fld(c)), 32'h1);
         check("R3 oc flag", 32'(status_word[15]), 1);
         check("R3 latch-off", 32'(latch_off), 32'(1 << c));
         oc_lvl[c] = 1'b0;
         tick(1);
         pulse_srst();
         check("R7 srst state", 32'(fld(c)), 32'h3);
         check("R7 flag clear", 32'(status_word[15]), 0);
         check("R7 latch clear", 32'(latch_off), 0);
      end

      // R3 restart on short pulse, R4 masking
      oc_lvl[0] = 1'b1; tick(OCD - 1);
      oc_lvl[0] = 1'b0; tick(1);
      oc_lvl[0] = 1'b1; tick(OCD - 1);
      check("R3 restart", 32'(fld(0)), 32'h3);
      tick(1);
      check("R3 after restart", 32'(fld(0)), 32'h1);
      oc_lvl[0] = 1'b0;
      ul_lvl[0] = 1'b1;
      tick(ULD + 5);
      check("R4 oc holds", 32'(fld(0)), 32'h1);
      check("R4 no ul flag", 32'(status_word[13]), 0);
      ul_lvl[0] = 1'b0;
      pulse_srst();

      // R5 shared timer, R6 no shutdown
      uld_shdn = 1'b0;
      ul_lvl[1] = 1'b1;
      tick(6);
      ul_lvl[2] = 1'b1;
      tick(ULD - 7);
      check("R5 ch1 waiting", 32'(fld(1)), 32'h3);
      check("R5 ch2 waiting", 32'(fld(2)), 32'h3);
      tick(1);
      check("R5 ch1 ul", 32'(fld(1)), 32'h2);
      check("R5 ch2 inherits", 32'(fld(2)), 32'h2);
      check("R5 ul flag", 32'(status_word[13]), 1);
      check("R6 no latch", 32'(latch_off), 0);
      // R4 overcurrent from under-load
      oc_lvl[1] = 1'b1;
      tick(OCD);
      check("R4 ul to oc", 32'(fld(1)), 32'h1);
      oc_lvl[1] = 1'b0;
      ul_lvl = '0;
      pulse_srst();
      check("R7 ch1 back", 32'(fld(1)), 32'h3);
      check("R7 ch2 back", 32'(fld(2)), 32'h3);
      check("R7 flags clear", 32'(status_word[15:13]), 0);

      // R6 shutdown enabled
      uld_shdn = 1'b1;
      ul_lvl[3] = 1'b1;
      tick(ULD);
      check("R6 ul state", 32'(fld(3)), 32'h2);
      check("R6 latch-off", 32'(latch_off), 32'h8);
      uld_shdn = 1'b0;
      ul_lvl[3] = 1'b0;
      tick(1);
      pulse_srst();
      check("R6 latch released", 32'(latch_off), 0);

      // R7 set wins over strobe
      oc_lvl[4] = 1'b1;
      tick(OCD - 1);
      srst = 1'b1; tick(1); srst = 1'b0;
      check("R7 set wins state", 32'(fld(4)), 32'h1);
      check("R7 set wins flag", 32'(status_word[15]), 1);
      // R2 disable from fault
      oc_lvl[4] = 1'b0;
      ch_en[4] = 1'b0;
      tick(1);
      check("R2 fault disabled", 32'(fld(4)), 0);
      check("R2 flag kept", 32'(status_word[15]), 1);
      ch_en[4] = 1'b1;
      pulse_srst();

      // R8 thermal shutdown
      tsd_lvl[5] = 1'b1;
      tick(1);
      check("R8 flag", 32'(tsd_flag), 1);
      check("R8 latch", 32'(latch_off), 32'h20);
      pulse_srst();
      check("R8 held while hot", 32'(tsd_flag), 1);
      tsd_lvl[5] = 1'b0;
      tick(2);
      check("R8 latched", 32'(latch_off), 32'h20);
      pulse_srst();
      check("R8 cleared", 32'(tsd_flag), 0);
      check("R8 latch cleared", 32'(latch_off), 0);

      // R9 warning and supply
      tw_lvl = 1'b1; tick(1);
      check("R9 tw set", 32'(status_word[0]), 1);
      tw_lvl = 1'b0; tick(1);
      check("R9 tw clear", 32'(status_word[0]), 0);
      uv_lvl = 1'b1; tick(1);
      check("R9 uv", 32'(status_word[14]), 1);
      uv_lvl = 1'b0; ov_lvl = 1'b1; tick(1);
      check("R9 ov", 32'(status_word[14]), 1);
      ov_lvl = 1'b0; tick(1);
      check("R9 clear", 32'(status_word[14]), 0);
      check("R10 word", 32'(status_word), 32'h1FFE);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule